// File: doc/BRIEF.md
# Banked Edge-Triggered Event Interrupt Controller

This block takes a set of external event lines, grouped into banks of 32, and turns them into one CPU interrupt request per line. Each configurable line is first brought into the clock domain through a two-stage synchroniser. Its rising and falling transitions are then latched into two separate pending flags, according to per-line trigger selects. Software clears a flag by writing one to it. A per-line mask decides which lines reach the interrupt output.

Lines that are not configurable skip edge detection. Their synchronised level, gated by the mask, drives the output directly. Which lines are configurable is fixed when the block is built. Software can read that set, together with a hardware description word, through a simple valid/write/address/data register port. Read data appears one clock after the read request.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset every trigger select, pending flag and mask bit reads 0, and every `irq_out` bit is 0.
- R2: A configurable line whose rising select is 1 (bank b at 0x20*b+0x00, bit n mod 32) sets its rising pending flag (0x20*b+0x0C) on a low-to-high input change. The flag reads 1 and the masked output rises on the third rising clock edge after the input changes, and not before. A falling change leaves the falling flag at 0 unless the falling select is also set.
- R3: A configurable line whose falling select is 1 (0x20*b+0x04) sets its falling pending flag (0x20*b+0x10) on a high-to-low input change, and ignores the rising change.
- R4: With both selects set, a line latches rising changes into the rising flag and falling changes into the falling flag.
- R5: For a configurable line, `irq_out` is (rising flag OR falling flag) AND mask bit, where bank b's mask is at 0x80+0x10*b. A masked line still latches its flag, and the output rises as soon as the mask bit is written to 1.
- R6: Writing 1 to a bit of a pending register clears that flag on the write edge. Bits written 0 keep their value, and a write to one pending register leaves the other register's flags unchanged.
- R7: When a new edge and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R8: Non-configurable lines ignore writes to their select bits, which read 0. They never set a pending flag. Their output follows the synchronised input AND mask, two rising clock edges after the input changes.
- R9: The read-only word at 0x3F0 reads {4'h0, CID width[3:0], 12'h0, (CPUs-1)[3:0], (lines-1)[7:0]}. With the default parameters this is 0x0300014F.
- R10: The read-only words at 0x3EC, 0x3E8 and 0x3E4 give the configurable-line masks of banks 0, 1 and 2. With the defaults these are 0xFFFFFFFF, 0xFFFF0000 and 0x000000FF.
- R11: Bits of lines at or above the line count (default 80) cannot be written and read 0 in every per-bank register.
- R12: A read of an unmapped, misaligned or absent-bank address returns 0. Writes to reserved or read-only addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| evt_in | input | NUM_LINES | Asynchronous external event lines |
| irq_out | output | NUM_LINES | Per-line CPU interrupt requests |

## Verification
The edge logic is driven with these input patterns, each on its own line:
- a rising-only select fed a full pulse, which separates rising latching from falling latching;
- a falling-only select fed the same pulse, which shows the opposite;
- both selects set, which shows that the two flags fill independently;
- a masked line, which separates latching from forwarding.

A clearing write is placed on the very cycle a falling edge lands, which tells set-priority from clear-priority. The cycle counts before the output rises distinguish the three-stage configurable path from the two-stage direct-level path. Writes of all ones to banks with non-configurable and absent lines show which bits are storable. Reads of reserved, misaligned and absent-bank addresses show that decode is exact.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

  localparam int LINES_PER_BANK = 32;
  localparam int MAX_BANKS      = 3;
  localparam int AW             = 12;
  localparam int DW             = 32;

  localparam logic [AW-1:0] OFS_RSEL    = 12'h000;
  localparam logic [AW-1:0] OFS_FSEL    = 12'h004;
  localparam logic [AW-1:0] OFS_RPND    = 12'h00C;
  localparam logic [AW-1:0] OFS_FPND    = 12'h010;
  localparam logic [AW-1:0] BANK_STRIDE = 12'h020;
  localparam logic [AW-1:0] MASK_BASE   = 12'h080;
  localparam logic [AW-1:0] MASK_STRIDE = 12'h010;
  localparam logic [AW-1:0] TRG_BASE    = 12'h3EC;
  localparam logic [AW-1:0] TRG_STRIDE  = 12'h004;
  localparam logic [AW-1:0] HWCFG_ADDR  = 12'h3F0;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_RSEL,
    FLD_FSEL,
    FLD_RPND,
    FLD_FPND,
    FLD_MASK,
    FLD_TRG,
    FLD_HWCFG
  } field_e;

  typedef struct packed {
    field_e     fld;
    logic [1:0] bank;
  } dec_t;

  // Exact-match decode of a word address; banks at or above nbanks are absent.
  function automatic dec_t decode_addr(input logic [AW-1:0] a, input int nbanks);
    dec_t d;
    logic [AW-1:0] bbase;
    d.fld  = FLD_NONE;
    d.bank = '0;
    for (int b = 0; b < MAX_BANKS; b++) begin
      if (b < nbanks) begin
        bbase = AW'(b) * BANK_STRIDE;
        if (a == bbase + OFS_RSEL) begin d.fld = FLD_RSEL; d.bank = 2'(b); end
        if (a == bbase + OFS_FSEL) begin d.fld = FLD_FSEL; d.bank = 2'(b); end
        if (a == bbase + OFS_RPND) begin d.fld = FLD_RPND; d.bank = 2'(b); end
        if (a == bbase + OFS_FPND) begin d.fld = FLD_FPND; d.bank = 2'(b); end
        if (a == MASK_BASE + AW'(b) * MASK_STRIDE) begin d.fld = FLD_MASK; d.bank = 2'(b); end
        if (a == TRG_BASE - AW'(b) * TRG_STRIDE)   begin d.fld = FLD_TRG;  d.bank = 2'(b); end
      end
    end
    if (a == HWCFG_ADDR) d.fld = FLD_HWCFG;
    return d;
  endfunction

  // Bits of a bank that correspond to existing lines.
  function automatic logic [DW-1:0] valid_bits(input int bank, input int nlines);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < LINES_PER_BANK; i++) begin
      if (bank * LINES_PER_BANK + i < nlines) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/evtc_sync.sv
module evtc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] s1_q, s2_q, s3_q;
  logic [W-1:0] s1_d, s2_d, s3_d;

  always_comb begin
    s1_d = din;
    s2_d = s1_q;
    s3_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
      s3_q <= s3_d;
    end
  end

  assign level = s2_q;
  assign rise  = s2_q & ~s3_q;
  assign fall  = ~s2_q & s3_q;

endmodule

// File: rtl/evtc_bank.sv
module evtc_bank #(
  parameter logic [31:0] CFG_MASK   = 32'h0,
  parameter logic [31:0] VALID_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_rsel,
  input  logic        we_fsel,
  input  logic        we_rpnd,
  input  logic        we_fpnd,
  input  logic        we_mask,
  input  logic [31:0] wdata,
  input  logic [31:0] level,
  input  logic [31:0] rise,
  input  logic [31:0] fall,
  output logic [31:0] rsel,
  output logic [31:0] fsel,
  output logic [31:0] rpnd,
  output logic [31:0] fpnd,
  output logic [31:0] mask,
  output logic [31:0] irq
);

  logic [31:0] rsel_q, fsel_q, rpnd_q, fpnd_q, mask_q;
  logic [31:0] rsel_d, fsel_d, rpnd_d, fpnd_d, mask_d;
  logic [31:0] rise_set, fall_set, rclr, fclr;
  logic        rsel_en, fsel_en, mask_en;

  always_comb begin
    rsel_en  = we_rsel;
    fsel_en  = we_fsel;
    mask_en  = we_mask;
    rsel_d   = wdata & CFG_MASK;
    fsel_d   = wdata & CFG_MASK;
    mask_d   = wdata & VALID_MASK;
    rise_set = rise & rsel_q & CFG_MASK;
    fall_set = fall & fsel_q & CFG_MASK;
    rclr     = we_rpnd ? (wdata & CFG_MASK) : '0;
    fclr     = we_fpnd ? (wdata & CFG_MASK) : '0;
    rpnd_d   = (rpnd_q & ~rclr) | rise_set;
    fpnd_d   = (fpnd_q & ~fclr) | fall_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= '0;
      fsel_q <= '0;
      rpnd_q <= '0;
      fpnd_q <= '0;
      mask_q <= '0;
    end else begin
      if (rsel_en) rsel_q <= rsel_d;
      if (fsel_en) fsel_q <= fsel_d;
      if (mask_en) mask_q <= mask_d;
      rpnd_q <= rpnd_d;
      fpnd_q <= fpnd_d;
    end
  end

  assign rsel = rsel_q;
  assign fsel = fsel_q;
  assign rpnd = rpnd_q;
  assign fpnd = fpnd_q;
  assign mask = mask_q;
  assign irq  = (((rpnd_q | fpnd_q) & CFG_MASK) | (level & ~CFG_MASK)) & mask_q;

  // R7
  rise_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_set != 32'h0) |=> ((rpnd_q & $past(rise_set)) == $past(rise_set)));

  // R7
  fall_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_set != 32'h0) |=> ((fpnd_q & $past(fall_set)) == $past(fall_set)));

  // R6
  rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rclr & ~rise_set) != 32'h0) |=> ((rpnd_q & $past(rclr & ~rise_set)) == 32'h0));

  // R6
  fall_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fclr & ~fall_set) != 32'h0) |=> ((fpnd_q & $past(fclr & ~fall_set)) == 32'h0));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evtc_pkg::*;
#(
  parameter int          NUM_LINES = 80,
  parameter int          NUM_CPUS  = 2,
  parameter int          CID_WIDTH = 3,
  parameter logic [95:0] CFG_LINES = 96'h0000_00FF_FFFF_0000_FFFF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] evt_in,
  output logic [NUM_LINES-1:0] irq_out
);

  localparam int NUM_BANKS = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK;
  localparam int PAD       = NUM_BANKS * LINES_PER_BANK;
  localparam logic [31:0] HWCFG_WORD =
    {4'h0, 4'(CID_WIDTH), 12'h000, 4'(NUM_CPUS - 1), 8'(NUM_LINES - 1)};

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_int_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_q  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_q  <= rst_meta_q;
    end
  end

  logic [NUM_LINES-1:0] lvl_n, rise_n, fall_n;
  logic [PAD-1:0]       lvl_p, rise_p, fall_p, irq_p;

  evtc_sync #(.W(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_q),
    .din   (evt_in),
    .level (lvl_n),
    .rise  (rise_n),
    .fall  (fall_n)
  );

  assign lvl_p  = PAD'(lvl_n);
  assign rise_p = PAD'(rise_n);
  assign fall_p = PAD'(fall_n);

  dec_t dec;
  logic wr_req, rd_req;
  assign dec    = decode_addr(bus_addr, NUM_BANKS);
  assign wr_req = bus_valid & bus_write;
  assign rd_req = bus_valid & ~bus_write;

  logic [NUM_BANKS-1:0]       we_rsel, we_fsel, we_rpnd, we_fpnd, we_mask;
  logic [NUM_BANKS-1:0][31:0] rsel_w, fsel_w, rpnd_w, fpnd_w, mask_w, trg_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [31:0] VMASK = valid_bits(b, NUM_LINES);
    localparam logic [31:0] CMASK = CFG_LINES[b*32 +: 32] & VMASK;

    assign we_rsel[b] = wr_req && (dec.fld == FLD_RSEL) && (dec.bank == 2'(b));
    assign we_fsel[b] = wr_req && (dec.fld == FLD_FSEL) && (dec.bank == 2'(b));
    assign we_rpnd[b] = wr_req && (dec.fld == FLD_RPND) && (dec.bank == 2'(b));
    assign we_fpnd[b] = wr_req && (dec.fld == FLD_FPND) && (dec.bank == 2'(b));
    assign we_mask[b] = wr_req && (dec.fld == FLD_MASK) && (dec.bank == 2'(b));
    assign trg_w[b]   = CMASK;

    evtc_bank #(.CFG_MASK(CMASK), .VALID_MASK(VMASK)) u_bank (
      .clk     (clk),
      .rst_n   (rst_int_q),
      .we_rsel (we_rsel[b]),
      .we_fsel (we_fsel[b]),
      .we_rpnd (we_rpnd[b]),
      .we_fpnd (we_fpnd[b]),
      .we_mask (we_mask[b]),
      .wdata   (bus_wdata),
      .level   (lvl_p[b*32 +: 32]),
      .rise    (rise_p[b*32 +: 32]),
      .fall    (fall_p[b*32 +: 32]),
      .rsel    (rsel_w[b]),
      .fsel    (fsel_w[b]),
      .rpnd    (rpnd_w[b]),
      .fpnd    (fpnd_w[b]),
      .mask    (mask_w[b]),
      .irq     (irq_p[b*32 +: 32])
    );
  end

  assign irq_out = irq_p[NUM_LINES-1:0];

  // Read path: mux next, registered data.
  logic [31:0] rd_d, rdata_q;
  logic        rd_en;

  always_comb begin
    rd_en = rd_req;
    rd_d  = '0;
    if (dec.fld == FLD_HWCFG) begin
      rd_d = HWCFG_WORD;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (dec.bank == 2'(b)) begin
          case (dec.fld)
            FLD_RSEL: rd_d = rsel_w[b];
            FLD_FSEL: rd_d = fsel_w[b];
            FLD_RPND: rd_d = rpnd_w[b];
            FLD_FPND: rd_d = fpnd_w[b];
            FLD_MASK: rd_d = mask_w[b];
            FLD_TRG:  rd_d = trg_w[b];
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_q) begin
    if (!rst_int_q) rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  // R9
  hwcfg_read_chk: assert property (@(posedge clk) disable iff (!rst_int_q)
    (rd_req && (bus_addr == HWCFG_ADDR)) |=> (bus_rdata == HWCFG_WORD));

  // R12
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_int_q)
    (rd_req && (dec.fld == FLD_NONE)) |=> (bus_rdata == 32'h0));

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL         = 80;
  localparam int K_RD  = 0;
  localparam int K_BIT = 1;
  localparam int K_ALL = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_valid, bus_write;
  logic [11:0]   bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic [NL-1:0] evt_in, irq_out;

  typedef struct {
    int          kind;
    int          line;
    logic [95:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    n_cmp  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  evt_irq_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: compares queued expectations away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [95:0] act;
        it = sbq.pop_front();
        case (it.kind)
          K_RD:    act = 96'(bus_rdata);
          K_BIT:   act = 96'(irq_out[it.line]);
          default: act = 96'(irq_out);
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    tick();
    bus_valid = 1'b0;
    it.kind = K_RD; it.line = 0; it.exp = 96'(e); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_bit(input int ln, input logic v, input string tag);
    item_t it;
    it.kind = K_BIT; it.line = ln; it.exp = 96'(v); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_all(input logic [NL-1:0] v, input string tag);
    item_t it;
    it.kind = K_ALL; it.line = 0; it.exp = 96'(v); it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; evt_in = '0;
    ticks(3);
    rst_n = 1'b1;
    ticks(3);

    // R1 reset state
    exp_all('0, "R1 irq_out after reset");
    rd(12'h000, 32'h0, "R1 rise select bank0");
    rd(12'h00C, 32'h0, "R1 rise pending bank0");
    rd(12'h080, 32'h0, "R1 mask bank0");
    rd(12'h090, 32'h0, "R1 mask bank1");

    // R9 / R10 read-only words
    rd(12'h3F0, 32'h0300_014F, "R9 hardware word");
    rd(12'h3EC, 32'hFFFF_FFFF, "R10 cfg mask bank0");
    rd(12'h3E8, 32'hFFFF_0000, "R10 cfg mask bank1");
    rd(12'h3E4, 32'h0000_00FF, "R10 cfg mask bank2");

    // Setup bank0: rise on 5,7,8; fall on 6,7; mask 5,6,7
    bwrite(12'h000, 32'h0000_01A0);
    bwrite(12'h004, 32'h0000_00C0);
    bwrite(12'h080, 32'h0000_00E0);

    // R2 rising only, line 5
    evt_in[5] = 1'b1;
    ticks(2);
    exp_bit(5, 1'b0, "R2 not before third edge");
    tick();
    exp_bit(5, 1'b1, "R2 rise latched");
    rd(12'h00C, 32'h0000_0020, "R2 rise pending");
    rd(12'h010, 32'h0, "R2 fall pending untouched");
    evt_in[5] = 1'b0;
    ticks(3);
    rd(12'h010, 32'h0, "R2 falling change ignored");
    exp_bit(5, 1'b1, "R2 flag held");
    bwrite(12'h00C, 32'h0000_0020);
    exp_bit(5, 1'b0, "R6 clear drops output");
    rd(12'h00C, 32'h0, "R6 rise flag cleared");

    // R3 falling only, line 6
    evt_in[6] = 1'b1;
    ticks(3);
    exp_bit(6, 1'b0, "R3 rising change ignored");
    rd(12'h00C, 32'h0, "R3 no rise flag");
    evt_in[6] = 1'b0;
    ticks(3);
    exp_bit(6, 1'b1, "R3 fall latched");
    rd(12'h010, 32'h0000_0040, "R3 fall pending");
    bwrite(12'h010, 32'h0);
    bwrite(12'h00C, 32'h0000_0040);
    rd(12'h010, 32'h0000_0040, "R6 zeros and other register keep flag");
    bwrite(12'h010, 32'h0000_0040);
    rd(12'h010, 32'h0, "R6 fall flag cleared");
    exp_bit(6, 1'b0, "R6 output low after clear");

    // R4 both edges, line 7
    evt_in[7] = 1'b1;
    ticks(3);
    rd(12'h00C, 32'h0000_0080, "R4 rise flag");
    bwrite(12'h00C, 32'h0000_0080);
    evt_in[7] = 1'b0;
    ticks(3);
    rd(12'h010, 32'h0000_0080, "R4 fall flag");
    rd(12'h00C, 32'h0, "R4 rise flag stays clear");
    exp_bit(7, 1'b1, "R4 output from fall flag");
    bwrite(12'h010, 32'h0000_0080);
    exp_bit(7, 1'b0, "R4 output low after clear");

    // R5 masked line 8
    evt_in[8] = 1'b1;
    ticks(3);
    exp_bit(8, 1'b0, "R5 masked output low");
    rd(12'h00C, 32'h0000_0100, "R5 flag latched while masked");
    bwrite(12'h080, 32'h0000_01E0);
    exp_bit(8, 1'b1, "R5 unmask releases");
    bwrite(12'h00C, 32'h0000_0100);
    exp_bit(8, 1'b0, "R5 output low after clear");
    evt_in[8] = 1'b0;
    ticks(3);

    // R7 edge and clear in the same cycle, line 7
    evt_in[7] = 1'b1;
    ticks(3);
    evt_in[7] = 1'b0;
    ticks(2);
    bwrite(12'h010, 32'h0000_0080);
    rd(12'h010, 32'h0000_0080, "R7 new edge beats clear");
    bwrite(12'h010, 32'h0000_0080);
    rd(12'h010, 32'h0, "R7 later clear works");
    bwrite(12'h00C, 32'h0000_0080);
    rd(12'h00C, 32'h0, "R7 rise flag cleared");

    // R8 non-configurable line 33, configurable line 50
    bwrite(12'h020, 32'hFFFF_FFFF);
    rd(12'h020, 32'hFFFF_0000, "R8 select bits of direct lines read 0");
    bwrite(12'h090, 32'h0004_0002);
    evt_in[33] = 1'b1;
    tick();
    exp_bit(33, 1'b0, "R8 level not after one edge");
    tick();
    exp_bit(33, 1'b1, "R8 level after two edges");
    rd(12'h02C, 32'h0, "R8 no pending on direct line");
    evt_in[33] = 1'b0;
    ticks(2);
    exp_bit(33, 1'b0, "R8 level follows input low");
    evt_in[50] = 1'b1;
    ticks(3);
    exp_bit(50, 1'b1, "R8 bank1 configurable line");
    rd(12'h02C, 32'h0004_0000, "R8 bank1 rise flag");
    bwrite(12'h02C, 32'hFFFF_FFFF);
    exp_bit(50, 1'b0, "R6 bank1 clear");

    // R11 absent lines in bank2
    bwrite(12'h0A0, 32'hFFFF_FFFF);
    rd(12'h0A0, 32'h0000_FFFF, "R11 mask of absent lines");
    bwrite(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, 32'h0000_00FF, "R11 select bank2");
    evt_in[70] = 1'b1;
    evt_in[75] = 1'b1;
    ticks(3);
    exp_bit(70, 1'b1, "R11 line70 edge");
    exp_bit(75, 1'b1, "R8 line75 level");
    rd(12'h04C, 32'h0000_0040, "R11 bank2 rise flag");
    exp_all((NL'(1) << 70) | (NL'(1) << 75), "R11 whole output");

    // R12 unmapped and read-only
    rd(12'h008, 32'h0, "R12 reserved word");
    rd(12'h060, 32'h0, "R12 absent bank");
    rd(12'h3F4, 32'h0, "R12 above hardware word");
    rd(12'h001, 32'h0, "R12 misaligned");
    bwrite(12'h008, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0000_01A0, "R12 reserved write ignored");
    bwrite(12'h3F0, 32'h0);
    rd(12'h3F0, 32'h0300_014F, "R12 hardware word not writable");
    bwrite(12'h3EC, 32'h0);
    rd(12'h3EC, 32'hFFFF_FFFF, "R12 cfg mask not writable");

    ticks(3);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule